// File: doc/BRIEF.md
# Multi-size integer divide unit

This block is a sequential integer divider for a processor execution stage. It takes a dividend, a divisor, a form select and a signedness select. It runs a radix-2 restoring loop for a fixed number of cycles and returns:

- a quotient and a remainder;
- write-enables and indices for two destination registers;
- the N, Z, V and C condition flags, each with its own update strobe;
- a divide-by-zero trap.

The register file and the instruction decoder stay outside the block. The block is told which register indices were named. It returns them with its write-enables.

Three forms are supported:

- **Short form** (`form` = 2'b00): a 32-bit dividend divided by the low 16 bits of `divisor`. The 16-bit quotient and 16-bit remainder are packed into one word.
- **Word form** (`form` = 2'b01, and the reserved code 2'b11): 32 bits by 32 bits.
- **Pair form** (`form` = 2'b10): a 64-bit dividend built from two register values, divided by 32 bits.

A result that does not fit its destination width is an overflow. On overflow no register is written, V is set and Z is cleared. When the two destination indices are equal, fixed rules decide which result reaches the register. A lean-pair option changes those rules for the word form.

Top module: `idiv_unit`

## Requirements
- R1: A zero divisor ends the operation one cycle after the start edge. `div0_trap` pulses with `done`, and `quo_we`, `rem_we`, `flags_we` and `n_we` all stay low. In the short form only `divisor[15:0]` is tested for zero.
- R2: An operation is accepted on a rising edge where `start` = 1 and `busy` = 0. `done` is a one-cycle pulse seen 33 cycles after the start edge for `form` 2'b00, 2'b01 and 2'b11, and 65 cycles after it for 2'b10. `busy` stays high until `done` rises. A `start` seen while `busy` = 1 is ignored.
- R3: With `is_signed` = 0, the operands are unsigned and the quotient and remainder are the truncated unsigned results.
- R4: With `is_signed` = 1, the quotient is truncated toward zero and a nonzero remainder takes the sign of the dividend.
- R5: The short form divides `src_lo` by `divisor[15:0]`, zero-extended when unsigned and sign-extended when signed. `quo_data` = {remainder[15:0], quotient[15:0]}, only `quo_we` is raised, and N and Z are taken from the 16-bit quotient.
- R6: A short-form overflow occurs when the unsigned quotient exceeds 0xFFFF, or when the signed quotient lies outside -32768..32767.
- R7: The pair form divides {`src_hi`, `src_lo`} (`src_hi` is the upper half). Overflow occurs when the quotient does not fit 32 bits: above 0xFFFFFFFF unsigned, or outside the 32-bit signed range. A signed word-form quotient outside the 32-bit signed range is also an overflow.
- R8: On overflow, `flags_we` = 1 with V = 1, Z = 0 and C = 0. `n_we` = 0, so N is left as it was. Both register write-enables stay low.
- R9: On a successful divide, `flags_we` = `n_we` = 1, C = 0 and V = 0. N is the top bit of the destination-width quotient, and Z is set exactly when that quotient is zero.
- R10: In the word and pair forms, with lean-pair off, distinct indices raise both `quo_we` and `rem_we`. Equal indices raise only `quo_we`, so the quotient is what reaches the register.
- R11: With `lean_pair` = 1, the word form raises only `quo_we` when the indices are equal and only `rem_we` when they differ. The short and pair forms are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation when idle |
| form | input | 2 | 00 short, 01 word, 10 pair, 11 same as word |
| is_signed | input | 1 | Two's-complement operands when 1 |
| lean_pair | input | 1 | Single-destination rule for the word form |
| src_lo | input | XLEN | Dividend (lower half in pair form) |
| src_hi | input | XLEN | Upper dividend half, pair form only |
| divisor | input | XLEN | Divisor (low half only in short form) |
| quo_idx | input | RIDX | Quotient destination index |
| rem_idx | input | RIDX | Remainder destination index |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| div0_trap | output | 1 | Divide-by-zero, with done |
| quo_data | output | XLEN | Quotient (packed pair in short form) |
| rem_data | output | XLEN | Remainder |
| quo_we | output | 1 | Write quotient register, with done |
| rem_we | output | 1 | Write remainder register, with done |
| quo_widx | output | RIDX | Index for quo_data |
| rem_widx | output | RIDX | Index for rem_data |
| flags_we | output | 1 | Update Z, V and C |
| n_we | output | 1 | Update N |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench targets the boundaries of the overflow rule:

- -32768 against 32768 in the short form;
- the most negative word divided by -1;
- 2^32 / 2 against 2^33 / 2 in the pair form.

A design that compares magnitudes instead of signed ranges would either write a wrapped quotient or flag a valid one.

It also checks a zero short divisor whose upper bits are set. A design that tests the full divisor word there would divide instead of trapping.

The bench covers equal and distinct destination indices with lean-pair on and off. A wrong enable rule would let the remainder reach the register, or drop a result.

Finally, it holds `start` high through a run with changed operands. A design that re-accepts `start` would return the second operand set's results.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    localparam logic [1:0] FORM_SHORT = 2'b00;
    localparam logic [1:0] FORM_WORD  = 2'b01;
    localparam logic [1:0] FORM_PAIR  = 2'b10;

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: magnitudes, result signs, loop length, zero test.
module idiv_prep #(
    parameter int XLEN = 32,
    parameter int DW   = 2 * XLEN,
    parameter int CW   = $clog2(DW + 1)
) (
    input  logic [1:0]      form,
    input  logic            sgn,
    input  logic [XLEN-1:0] src_lo,
    input  logic [XLEN-1:0] src_hi,
    input  logic [XLEN-1:0] divisor,
    output logic [DW-1:0]   qinit,
    output logic [XLEN-1:0] den_mag,
    output logic            q_neg,
    output logic            r_neg,
    output logic [CW-1:0]   steps,
    output logic            den_zero
);
    localparam int HLEN = XLEN / 2;

    logic            is_short, is_pair;
    logic [XLEN-1:0] den_raw;
    logic [DW-1:0]   num_raw, num_mag;
    logic            num_neg, den_neg;

    always_comb begin
        is_short = (form == idiv_pkg::FORM_SHORT);
        is_pair  = (form == idiv_pkg::FORM_PAIR);

        if (is_short)
            den_raw = {{HLEN{sgn & divisor[HLEN-1]}}, divisor[HLEN-1:0]};
        else
            den_raw = divisor;
        den_neg  = sgn & den_raw[XLEN-1];
        den_mag  = den_neg ? (~den_raw + 1'b1) : den_raw;
        den_zero = (den_raw == '0);

        if (is_pair)
            num_raw = {src_hi, src_lo};
        else
            num_raw = {{XLEN{sgn & src_lo[XLEN-1]}}, src_lo};
        num_neg = sgn & num_raw[DW-1];
        num_mag = num_neg ? (~num_raw + 1'b1) : num_raw;

        qinit = is_pair ? num_mag : {num_mag[XLEN-1:0], {XLEN{1'b0}}};
        steps = is_pair ? CW'(DW) : CW'(XLEN);
        q_neg = num_neg ^ den_neg;
        r_neg = num_neg;
    end
endmodule

// File: rtl/idiv_step.sv
// One restoring iteration: shift one dividend bit in, trial-subtract.
module idiv_step #(
    parameter int XLEN = 32,
    parameter int DW   = 2 * XLEN
) (
    input  logic [XLEN-1:0] part_in,
    input  logic [DW-1:0]   qacc_in,
    input  logic [XLEN-1:0] den,
    output logic [XLEN-1:0] part_out,
    output logic [DW-1:0]   qacc_out
);
    logic [XLEN:0] shifted, trial;

    always_comb begin
        shifted = {part_in, qacc_in[DW-1]};
        trial   = shifted - {1'b0, den};
        if (!trial[XLEN]) begin
            part_out = trial[XLEN-1:0];
            qacc_out = {qacc_in[DW-2:0], 1'b1};
        end else begin
            part_out = shifted[XLEN-1:0];
            qacc_out = {qacc_in[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/idiv_post.sv
// Sign restore, overflow detection, packing, flags and write-enable rules.
module idiv_post #(
    parameter int XLEN = 32,
    parameter int DW   = 2 * XLEN
) (
    input  logic [DW-1:0]   qmag,
    input  logic [XLEN-1:0] rmag,
    input  logic            q_neg,
    input  logic            r_neg,
    input  logic [1:0]      form,
    input  logic            sgn,
    input  logic            lean,
    input  logic            same_idx,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem,
    output logic            q_we,
    output logic            r_we,
    output logic            ovf,
    output logic            n,
    output logic            z
);
    localparam int HLEN = XLEN / 2;

    logic            is_short, is_pair;
    logic [DW-1:0]   qv, half, full;
    logic [XLEN-1:0] rv;

    always_comb begin
        is_short = (form == idiv_pkg::FORM_SHORT);
        is_pair  = (form == idiv_pkg::FORM_PAIR);
        qv   = q_neg ? (~qmag + 1'b1) : qmag;
        rv   = r_neg ? (~rmag + 1'b1) : rmag;
        half = is_short ? (DW'(1) << (HLEN - 1)) : (DW'(1) << (XLEN - 1));
        full = half << 1;

        if (sgn)
            ovf = q_neg ? (qmag > half) : (qmag >= half);
        else
            ovf = (qmag >= full);

        if (is_short) begin
            n   = qv[HLEN-1];
            z   = (qv[HLEN-1:0] == '0);
            quo = {rv[HLEN-1:0], qv[HLEN-1:0]};
        end else begin
            n   = qv[XLEN-1];
            z   = (qv[XLEN-1:0] == '0);
            quo = qv[XLEN-1:0];
        end
        rem = rv;

        if (ovf) begin
            q_we = 1'b0;
            r_we = 1'b0;
        end else if (is_short) begin
            q_we = 1'b1;
            r_we = 1'b0;
        end else if (!is_pair && lean) begin
            q_we = same_idx;
            r_we = !same_idx;
        end else begin
            q_we = 1'b1;
            r_we = !same_idx;
        end
    end
endmodule

// File: rtl/idiv_unit.sv
module idiv_unit #(
    parameter int XLEN = 32,
    parameter int RIDX = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      form,
    input  logic            is_signed,
    input  logic            lean_pair,
    input  logic [XLEN-1:0] src_lo,
    input  logic [XLEN-1:0] src_hi,
    input  logic [XLEN-1:0] divisor,
    input  logic [RIDX-1:0] quo_idx,
    input  logic [RIDX-1:0] rem_idx,
    output logic            busy,
    output logic            done,
    output logic            div0_trap,
    output logic [XLEN-1:0] quo_data,
    output logic [XLEN-1:0] rem_data,
    output logic            quo_we,
    output logic            rem_we,
    output logic [RIDX-1:0] quo_widx,
    output logic [RIDX-1:0] rem_widx,
    output logic            flags_we,
    output logic            n_we,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c
);
    import idiv_pkg::*;

    localparam int DW = 2 * XLEN;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        state_e          st;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] part;
        logic [DW-1:0]   qacc;
        logic [XLEN-1:0] den;
        logic            qneg;
        logic            rneg;
        logic [1:0]      form;
        logic            sgn;
        logic            lean;
        logic            dz;
        logic [RIDX-1:0] qi;
        logic [RIDX-1:0] ri;
        logic            done;
        logic            trap;
        logic [XLEN-1:0] qo;
        logic [XLEN-1:0] ro;
        logic            qwe;
        logic            rwe;
        logic            fwe;
        logic            nwe;
        logic            n;
        logic            z;
        logic            v;
        logic            c;
    } regs_t;

    regs_t nxt_d, cur_q;

    logic [DW-1:0]   p_qinit;
    logic [XLEN-1:0] p_den;
    logic            p_qneg, p_rneg, p_dz;
    logic [CW-1:0]   p_steps;
    logic [XLEN-1:0] s_part;
    logic [DW-1:0]   s_qacc;
    logic [XLEN-1:0] o_quo, o_rem;
    logic            o_qwe, o_rwe, o_ovf, o_n, o_z;

    idiv_prep #(.XLEN(XLEN), .DW(DW), .CW(CW)) u_prep (
        .form     (form),
        .sgn      (is_signed),
        .src_lo   (src_lo),
        .src_hi   (src_hi),
        .divisor  (divisor),
        .qinit    (p_qinit),
        .den_mag  (p_den),
        .q_neg    (p_qneg),
        .r_neg    (p_rneg),
        .steps    (p_steps),
        .den_zero (p_dz)
    );

    idiv_step #(.XLEN(XLEN), .DW(DW)) u_step (
        .part_in  (cur_q.part),
        .qacc_in  (cur_q.qacc),
        .den      (cur_q.den),
        .part_out (s_part),
        .qacc_out (s_qacc)
    );

    idiv_post #(.XLEN(XLEN), .DW(DW)) u_post (
        .qmag     (cur_q.qacc),
        .rmag     (cur_q.part),
        .q_neg    (cur_q.qneg),
        .r_neg    (cur_q.rneg),
        .form     (cur_q.form),
        .sgn      (cur_q.sgn),
        .lean     (cur_q.lean),
        .same_idx (cur_q.qi == cur_q.ri),
        .quo      (o_quo),
        .rem      (o_rem),
        .q_we     (o_qwe),
        .r_we     (o_rwe),
        .ovf      (o_ovf),
        .n        (o_n),
        .z        (o_z)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.trap = 1'b0;
        nxt_d.qwe  = 1'b0;
        nxt_d.rwe  = 1'b0;
        nxt_d.fwe  = 1'b0;
        nxt_d.nwe  = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.part = '0;
                    nxt_d.qacc = p_qinit;
                    nxt_d.den  = p_den;
                    nxt_d.qneg = p_qneg;
                    nxt_d.rneg = p_rneg;
                    nxt_d.form = form;
                    nxt_d.sgn  = is_signed;
                    nxt_d.lean = lean_pair;
                    nxt_d.dz   = p_dz;
                    nxt_d.qi   = quo_idx;
                    nxt_d.ri   = rem_idx;
                    nxt_d.cnt  = p_steps - 1'b1;
                    nxt_d.st   = p_dz ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                nxt_d.part = s_part;
                nxt_d.qacc = s_qacc;
                if (cur_q.cnt == '0)
                    nxt_d.st = ST_FIN;
                else
                    nxt_d.cnt = cur_q.cnt - 1'b1;
            end
            ST_FIN: begin
                nxt_d.st   = ST_IDLE;
                nxt_d.done = 1'b1;
                if (cur_q.dz) begin
                    nxt_d.trap = 1'b1;
                end else begin
                    nxt_d.qo  = o_quo;
                    nxt_d.ro  = o_rem;
                    nxt_d.qwe = o_qwe;
                    nxt_d.rwe = o_rwe;
                    nxt_d.fwe = 1'b1;
                    nxt_d.c   = 1'b0;
                    nxt_d.v   = o_ovf;
                    nxt_d.z   = o_ovf ? 1'b0 : o_z;
                    if (!o_ovf) begin
                        nxt_d.nwe = 1'b1;
                        nxt_d.n   = o_n;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign busy      = (cur_q.st != ST_IDLE);
    assign done      = cur_q.done;
    assign div0_trap = cur_q.trap;
    assign quo_data  = cur_q.qo;
    assign rem_data  = cur_q.ro;
    assign quo_we    = cur_q.qwe;
    assign rem_we    = cur_q.rwe;
    assign quo_widx  = cur_q.qi;
    assign rem_widx  = cur_q.ri;
    assign flags_we  = cur_q.fwe;
    assign n_we      = cur_q.nwe;
    assign flag_n    = cur_q.n;
    assign flag_z    = cur_q.z;
    assign flag_v    = cur_q.v;
    assign flag_c    = cur_q.c;

endmodule

// File: rtl/idiv_unit_chk.sv
module idiv_unit_chk #(
    parameter int RIDX = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            div0_trap,
    input logic            quo_we,
    input logic            rem_we,
    input logic [RIDX-1:0] quo_widx,
    input logic [RIDX-1:0] rem_widx,
    input logic            flags_we,
    input logic            n_we,
    input logic            flag_z,
    input logic            flag_v,
    input logic            flag_c
);
    // R1
    div0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div0_trap |-> (done && !quo_we && !rem_we && !flags_we && !n_we));

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && flag_v) |-> (!quo_we && !rem_we && !n_we && !flag_z));

    // R9
    carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> !flag_c);

    // R10
    dest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quo_we && rem_we) |-> (quo_widx != rem_widx));

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    update_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we || quo_we || rem_we) |-> done);
endmodule

bind idiv_unit idiv_unit_chk #(.RIDX(RIDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .div0_trap (div0_trap),
    .quo_we    (quo_we),
    .rem_we    (rem_we),
    .quo_widx  (quo_widx),
    .rem_widx  (rem_widx),
    .flags_we  (flags_we),
    .n_we      (n_we),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c)
);

// File: tb/idiv_unit_tb.sv
`timescale 1ns/1ps
module idiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  form = 2'b00;
    logic        is_signed = 1'b0;
    logic        lean_pair = 1'b0;
    logic [31:0] src_lo = '0, src_hi = '0, divisor = '0;
    logic [2:0]  quo_idx = '0, rem_idx = '0;
    logic        busy, done, div0_trap, quo_we, rem_we, flags_we, n_we;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [31:0] quo_data, rem_data;
    logic [2:0]  quo_widx, rem_widx;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    idiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .form(form),
        .is_signed(is_signed), .lean_pair(lean_pair),
        .src_lo(src_lo), .src_hi(src_hi), .divisor(divisor),
        .quo_idx(quo_idx), .rem_idx(rem_idx),
        .busy(busy), .done(done), .div0_trap(div0_trap),
        .quo_data(quo_data), .rem_data(rem_data),
        .quo_we(quo_we), .rem_we(rem_we),
        .quo_widx(quo_widx), .rem_widx(rem_widx),
        .flags_we(flags_we), .n_we(n_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: arithmetic on 64-bit magnitudes, then the rules.
    task automatic run_op(input string req, input logic [1:0] f, input logic s,
                          input logic ln, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] dv, input logic [2:0] qi,
                          input logic [2:0] ri, input bit hold_start);
        logic [63:0] num, dm_raw, nm, dm, qm, rm, qv, rv, half;
        bit nneg, dneg, qn, zero, ovf, exp_qwe, exp_rwe, exp_n, exp_z;
        int w, lat;
        logic [31:0] exp_quo;

        if (f == 2'b00) dm_raw = s ? {{48{dv[15]}}, dv[15:0]} : {48'b0, dv[15:0]};
        else            dm_raw = s ? {{32{dv[31]}}, dv} : {32'b0, dv};
        if (f == 2'b10) num = {hi, lo};
        else            num = s ? {{32{lo[31]}}, lo} : {32'b0, lo};
        nneg = s && num[63];
        dneg = s && dm_raw[63];
        nm = nneg ? -num : num;
        dm = dneg ? -dm_raw : dm_raw;
        zero = (dm == 0);
        qm = zero ? 64'd0 : nm / dm;
        rm = zero ? 64'd0 : nm % dm;
        qn = nneg ^ dneg;
        w = (f == 2'b00) ? 16 : 32;
        half = 64'd1 << (w - 1);
        if (s) ovf = qn ? (qm > half) : (qm >= half);
        else   ovf = (qm >= (half << 1));
        qv = qn ? -qm : qm;
        rv = nneg ? -rm : rm;
        exp_n = (w == 16) ? qv[15] : qv[31];
        exp_z = (w == 16) ? (qv[15:0] == 0) : (qv[31:0] == 0);
        exp_quo = (w == 16) ? {rv[15:0], qv[15:0]} : qv[31:0];
        if (ovf) begin exp_qwe = 0; exp_rwe = 0; end
        else if (f == 2'b00) begin exp_qwe = 1; exp_rwe = 0; end
        else if (f != 2'b10 && ln) begin exp_qwe = (qi == ri); exp_rwe = (qi != ri); end
        else begin exp_qwe = 1; exp_rwe = (qi != ri); end
        lat = zero ? 1 : ((f == 2'b10) ? 65 : 33);

        @(negedge clk);
        form = f; is_signed = s; lean_pair = ln; src_lo = lo; src_hi = hi;
        divisor = dv; quo_idx = qi; rem_idx = ri; start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < lat; k++) begin
            if (k > 0) @(negedge clk);
            if (hold_start) begin
                src_lo = lo ^ 32'h0000_5A5A; divisor = dv + 32'd3;
            end else begin
                start = 1'b0;
            end
            chk("R2", "busy while running", {63'd0, busy}, 64'd1);
            chk("R2", "no early done", {63'd0, done}, 64'd0);
        end
        @(negedge clk);
        start = 1'b0;
        chk("R2", "done pulse", {63'd0, done}, 64'd1);
        chk("R2", "idle after done", {63'd0, busy}, 64'd0);
        chk("R1", "trap", {63'd0, div0_trap}, {63'd0, zero});
        if (zero) begin
            chk("R1", "no writes or flags", {60'd0, quo_we, rem_we, flags_we, n_we}, 64'd0);
        end else begin
            chk(req, "quo_we", {63'd0, quo_we}, {63'd0, exp_qwe});
            chk(req, "rem_we", {63'd0, rem_we}, {63'd0, exp_rwe});
            if (exp_qwe) begin
                chk(req, "quotient", {32'd0, quo_data}, {32'd0, exp_quo});
                chk(req, "quotient index", {61'd0, quo_widx}, {61'd0, qi});
            end
            if (exp_rwe) begin
                chk(req, "remainder", {32'd0, rem_data}, {32'd0, rv[31:0]});
                chk(req, "remainder index", {61'd0, rem_widx}, {61'd0, ri});
            end
            chk("R9", "flags_we / C", {62'd0, flags_we, flag_c}, 64'd2);
            if (ovf) begin
                chk("R8", "overflow V/Z/n_we", {61'd0, flag_v, flag_z, n_we}, 64'd4);
            end else begin
                chk("R9", "N/Z/V/n_we", {60'd0, flag_n, flag_z, flag_v, n_we},
                    {60'd0, exp_n, exp_z, 1'b0, 1'b1});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2", "reset busy", {63'd0, busy}, 64'd0);
        chk("R2", "reset done", {63'd0, done}, 64'd0);
        rst_n = 1'b1;

        // R3 unsigned short and word, R5 packing
        run_op("R5", 2'b00, 0, 0, 32'd100000, 0, 32'd7, 3'd1, 3'd2, 0);
        run_op("R3", 2'b01, 0, 0, 32'hFFFF_FFFF, 0, 32'd3, 3'd1, 3'd2, 0);
        run_op("R3", 2'b01, 0, 0, 32'd5, 0, 32'd7, 3'd4, 3'd5, 0);
        // R6 short overflow edges
        run_op("R6", 2'b00, 0, 0, 32'h0001_0000, 0, 32'd1, 3'd1, 3'd2, 0);
        run_op("R6", 2'b00, 1, 0, 32'd32768, 0, 32'd1, 3'd1, 3'd2, 0);
        run_op("R6", 2'b00, 1, 0, 32'hFFFF_8000, 0, 32'd1, 3'd1, 3'd2, 0);
        // R4 signed truncation and remainder sign
        run_op("R4", 2'b00, 1, 0, -32'sd7, 0, 32'd2, 3'd0, 3'd1, 0);
        run_op("R4", 2'b00, 1, 0, 32'd7, 0, 32'h0000_FFFE, 3'd0, 3'd1, 0);
        run_op("R4", 2'b01, 1, 0, -32'sd100, 0, 32'd7, 3'd3, 3'd6, 0);
        run_op("R7", 2'b01, 1, 0, 32'h8000_0000, 0, 32'hFFFF_FFFF, 3'd3, 3'd6, 0);
        // R1 zero divisor; short form tests only the low half
        run_op("R1", 2'b00, 0, 0, 32'd55, 0, 32'h0001_0000, 3'd1, 3'd2, 0);
        run_op("R1", 2'b10, 1, 0, 32'd55, 32'd9, 32'd0, 3'd1, 3'd2, 0);
        // R7 pair form
        run_op("R7", 2'b10, 0, 0, 32'd0, 32'd1, 32'd2, 3'd1, 3'd2, 0);
        run_op("R7", 2'b10, 0, 0, 32'd0, 32'd2, 32'd2, 3'd1, 3'd2, 0);
        run_op("R7", 2'b10, 1, 0, 32'd0, 32'hFFFF_FFFF, 32'd2, 3'd1, 3'd2, 0);
        run_op("R7", 2'b10, 1, 0, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 3'd1, 3'd2, 0);
        run_op("R7", 2'b10, 0, 0, 32'h1234_5678, 32'h0000_0007, 32'h0001_0003, 3'd4, 3'd5, 0);
        // R10 equal indices: quotient only
        run_op("R10", 2'b01, 0, 0, 32'd1000, 0, 32'd33, 3'd5, 3'd5, 0);
        run_op("R10", 2'b10, 1, 0, 32'd1000, 32'd0, 32'd33, 3'd5, 3'd5, 0);
        // R11 lean mode
        run_op("R11", 2'b01, 0, 1, 32'd1000, 0, 32'd33, 3'd5, 3'd5, 0);
        run_op("R11", 2'b01, 1, 1, -32'sd1000, 0, 32'd33, 3'd5, 3'd2, 0);
        run_op("R11", 2'b10, 0, 1, 32'd1000, 32'd0, 32'd33, 3'd5, 3'd2, 0);
        run_op("R11", 2'b00, 0, 1, 32'd1000, 0, 32'd33, 3'd5, 3'd2, 0);
        // R2 start held high while busy is ignored
        run_op("R2", 2'b01, 0, 0, 32'd999, 0, 32'd10, 3'd1, 3'd2, 1);
        // mixed patterns
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b, c;
            logic [1:0] f;
            a = $urandom; b = $urandom; c = $urandom;
            f = 2'($urandom % 3);
            if (i % 3 == 0) c = c >> 20;
            if (f == 2'b10 && i % 2 == 0) b = b >> 24;
            run_op(f == 2'b00 ? "R5" : "R3", f, 1'($urandom % 2), 1'($urandom % 2),
                   a, b, c, 3'($urandom), 3'($urandom), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule